// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches the processor's instruction fetches and data accesses and raises debug events when programmed conditions are met. It holds eight independent 32-bit comparators. Comparators 0 to 3 watch the instruction fetch address. Comparators 4 and 5 watch the data access address. Comparators 6 and 7 watch the data value of the access. Each comparator holds a reference value and a small control field. The control field picks the test (equal, below, above or off), enables the comparator, and says whether a hit also asks the core to break.

A debug agent programs the references and controls through a simple write port. When an enabled comparator fires, its event line pulses for one cycle and a sticky status bit records it. If any firing comparator has its break bit set, a break request pulses to the core in the same cycle as the event. The debug agent clears the status bits by writing ones to a dedicated clear address.

Top module: `dbgwp_top`

## Requirements
- R1: After reset, all event lines, the break request and all sticky bits are 0. All references are 0 and all controls are 0, so every comparator is disabled.
- R2: Comparators 0–3 compare against the fetch address. Comparators 4–5 compare against the data access address. Comparators 6–7 compare against the data value.
- R3: Control bits [1:0] select the test, with all comparisons unsigned over 32 bits. The codes are: 00 fires when observed == reference; 01 fires when observed < reference; 10 fires when observed > reference; 11 never fires.
- R4: Comparators 0–3 are evaluated only in cycles where `fetch_vld` is 1. Comparators 4–7 are evaluated only in cycles where `dacc_vld` is 1.
- R5: Comparator k fires only when its control bit 2 (enable) is 1.
- R6: `wp_event[k]` is 1 in the cycle after a cycle in which comparator k fired, and is otherwise 0.
- R7: `brk_req` is 1 in the cycle after a cycle in which at least one firing comparator had control bit 3 (break enable) set, and is otherwise 0.
- R8: Sticky bit k is set by a firing of comparator k, starting in the cycle after the firing. It stays set until a write to address 16 with data bit k equal to 1. Writing a 0 in bit k leaves it unchanged.
- R9: If a clear of sticky bit k and a firing of comparator k fall in the same cycle, the bit ends up set.
- R10: The write port map is as follows. Addresses 0–7 load the reference of comparator 0–7. Addresses 8–15 load the control (data bits [3:0]) of comparator 0–7. Address 16 clears sticky bits (data bits [7:0]). Writes to addresses 17–31 change nothing. A write affects accesses only from the following cycle onward; an access in the same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe of the programming port |
| cfg_addr | input | 5 | Programming address |
| cfg_wdata | input | 32 | Programming write data |
| fetch_vld | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| dacc_vld | input | 1 | Data access in this cycle |
| dacc_addr | input | 32 | Data access address |
| dacc_data | input | 32 | Data access value |
| wp_event | output | 8 | Per-comparator event pulse |
| brk_req | output | 1 | Breakpoint request to the core |
| wp_sticky | output | 8 | Sticky per-comparator status |

## Verification
A corrupted reference or control register shows up at the ports as a missing or spurious `wp_event` bit, one cycle after the first access that reaches it. The sticky vector then diverges in the same cycle and keeps the error visible. A stuck or wrongly held sticky bit is exposed by the next clear write, one cycle later. A broken break-enable path shows as a `brk_req` that disagrees with the event lines, also one cycle after the access. The scoreboard compares events, break request and sticky bits in every driven cycle, so each fault is caught within a cycle of its first effect.

// File: rtl/dbgwp_pkg.sv
package dbgwp_pkg;

  typedef enum logic [1:0] {
    COND_EQ  = 2'b00,
    COND_LT  = 2'b01,
    COND_GT  = 2'b10,
    COND_OFF = 2'b11
  } cond_e;

  typedef struct packed {
    logic  brk_en;
    logic  en;
    cond_e cond;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dbgwp_cfg.sv
module dbgwp_cfg
  import dbgwp_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [N-1:0][DW-1:0]   ref_o,
  output ctrl_t [N-1:0]          ctrl_o,
  output logic                   clr_we_o,
  output logic [N-1:0]           clr_mask_o
);

  localparam logic [AW-1:0] CLR_ADDR = AW'(2 * N);

  logic [N-1:0][DW-1:0] ref_q, ref_d;
  ctrl_t [N-1:0]        ctrl_q, ctrl_d;
  logic                 upd_en;

  always_comb begin
    ref_d  = ref_q;
    ctrl_d = ctrl_q;
    upd_en = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (we_i && addr_i == AW'(k)) begin
        ref_d[k] = wdata_i;
        upd_en   = 1'b1;
      end
      if (we_i && addr_i == AW'(N + k)) begin
        ctrl_d[k] = ctrl_t'(wdata_i[CTRL_W-1:0]);
        upd_en    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      ctrl_q <= '0;
    end else if (upd_en) begin
      ref_q  <= ref_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ref_o      = ref_q;
  assign ctrl_o     = ctrl_q;
  assign clr_we_o   = we_i && (addr_i == CLR_ADDR);
  assign clr_mask_o = wdata_i[N-1:0];

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i > CLR_ADDR) |=> ($stable(ref_q) && $stable(ctrl_q)));

endmodule

// File: rtl/dbgwp_cmp.sv
module dbgwp_cmp
  import dbgwp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          vld_i,
  input  logic [DW-1:0] obs_i,
  input  logic [DW-1:0] ref_i,
  input  ctrl_t         ctrl_i,
  output logic          hit_o
);

  logic cond_ok;

  always_comb begin
    case (ctrl_i.cond)
      COND_EQ: cond_ok = (obs_i == ref_i);
      COND_LT: cond_ok = (obs_i <  ref_i);
      COND_GT: cond_ok = (obs_i >  ref_i);
      default: cond_ok = 1'b0;
    endcase
  end

  assign hit_o = vld_i && ctrl_i.en && cond_ok;

  // R3
  always_comb begin
    if (ctrl_i.cond == COND_OFF) begin
      off_never_hits_chk: assert (!hit_o);
    end
  end

endmodule

// File: rtl/dbgwp_status.sv
module dbgwp_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] brk_en_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] event_o,
  output logic         brk_o,
  output logic [N-1:0] sticky_o
);

  logic [N-1:0] sticky_q, sticky_d, event_q, event_d;
  logic         brk_q, brk_d, sticky_en;

  always_comb begin
    event_d   = hit_i;
    brk_d     = |(hit_i & brk_en_i);
    sticky_en = clr_we_i || (|hit_i);
    sticky_d  = (sticky_q & ~(clr_we_i ? clr_mask_i : '0)) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= '0;
      brk_q   <= 1'b0;
    end else begin
      event_q <= event_d;
      brk_q   <= brk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else if (sticky_en) begin
      sticky_q <= sticky_d;
    end
  end

  assign event_o  = event_q;
  assign brk_o    = brk_q;
  assign sticky_o = sticky_q;

  // R7
  brk_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> (|event_q));

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[k] && !(clr_we_i && clr_mask_i[k])) |=> sticky_q[k]);
    // R6
    event_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_q[k] |-> sticky_q[k]);
  end

endmodule

// File: rtl/dbgwp_top.sv
module dbgwp_top
  import dbgwp_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned N_IA = 4,
  parameter int unsigned N_DA = 2,
  parameter int unsigned N_DV = 2,
  parameter int unsigned N    = N_IA + N_DA + N_DV,
  parameter int unsigned AW   = $clog2(2 * N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          fetch_vld,
  input  logic [DW-1:0] fetch_addr,
  input  logic          dacc_vld,
  input  logic [DW-1:0] dacc_addr,
  input  logic [DW-1:0] dacc_data,
  output logic [N-1:0]  wp_event,
  output logic          brk_req,
  output logic [N-1:0]  wp_sticky
);

  localparam int unsigned DA_LO = N_IA;
  localparam int unsigned DV_LO = N_IA + N_DA;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [N-1:0][DW-1:0] ref_w;
  ctrl_t [N-1:0]        ctrl_w;
  logic                 clr_we_w;
  logic [N-1:0]         clr_mask_w;
  logic [N-1:0]         hit_w;
  logic [N-1:0]         brk_en_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dbgwp_cfg #(.N(N), .DW(DW), .AW(AW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we_i       (cfg_we),
    .addr_i     (cfg_addr),
    .wdata_i    (cfg_wdata),
    .ref_o      (ref_w),
    .ctrl_o     (ctrl_w),
    .clr_we_o   (clr_we_w),
    .clr_mask_o (clr_mask_w)
  );

  for (genvar k = 0; k < N; k++) begin : g_cmp
    logic          vld_k;
    logic [DW-1:0] obs_k;
    if (k < DA_LO) begin : g_ia
      assign vld_k = fetch_vld;
      assign obs_k = fetch_addr;
    end else if (k < DV_LO) begin : g_da
      assign vld_k = dacc_vld;
      assign obs_k = dacc_addr;
    end else begin : g_dv
      assign vld_k = dacc_vld;
      assign obs_k = dacc_data;
    end
    assign brk_en_w[k] = ctrl_w[k].brk_en;
    dbgwp_cmp #(.DW(DW)) u_cmp (
      .vld_i  (vld_k),
      .obs_i  (obs_k),
      .ref_i  (ref_w[k]),
      .ctrl_i (ctrl_w[k]),
      .hit_o  (hit_w[k])
    );
  end

  dbgwp_status #(.N(N)) u_status (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hit_i      (hit_w),
    .brk_en_i   (brk_en_w),
    .clr_we_i   (clr_we_w),
    .clr_mask_i (clr_mask_w),
    .event_o    (wp_event),
    .brk_o      (brk_req),
    .sticky_o   (wp_sticky)
  );

  // R4
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fetch_vld && !dacc_vld) |=> (wp_event == '0 && !brk_req));

  // R4
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fetch_vld |=> (wp_event[N_IA-1:0] == '0));

  // R4
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dacc_vld |=> (wp_event[N-1:N_IA] == '0));

endmodule

// File: tb/tb_dbgwp_top.sv
module tb_dbgwp_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        dacc_vld = 1'b0;
  logic [31:0] dacc_addr = '0;
  logic [31:0] dacc_data = '0;
  logic [7:0]  wp_event;
  logic        brk_req;
  logic [7:0]  wp_sticky;

  always #2 clk = ~clk;

  dbgwp_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .dacc_vld(dacc_vld), .dacc_addr(dacc_addr), .dacc_data(dacc_data),
    .wp_event(wp_event), .brk_req(brk_req), .wp_sticky(wp_sticky)
  );

  typedef struct {
    logic [7:0] ev;
    logic       brk;
    logic [7:0] st;
    int         due;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;

  logic [31:0] ref_m [N];
  logic [3:0]  ctrl_m [N];
  logic [7:0]  st_m = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] model_hits(logic iv, logic [31:0] ia,
      logic dv, logic [31:0] da, logic [31:0] dd);
    logic [7:0] h = '0;
    for (int k = 0; k < N; k++) begin
      logic v; logic [31:0] o; logic c;
      v = (k < 4) ? iv : dv;
      o = (k < 4) ? ia : ((k < 6) ? da : dd);
      case (ctrl_m[k][1:0])
        2'b00: c = (o == ref_m[k]);
        2'b01: c = (o < ref_m[k]);
        2'b10: c = (o > ref_m[k]);
        default: c = 1'b0;
      endcase
      h[k] = v && ctrl_m[k][2] && c;
    end
    return h;
  endfunction

  task automatic drive(logic we, logic [4:0] a, logic [31:0] wd,
      logic iv, logic [31:0] ia, logic dv, logic [31:0] da, logic [31:0] dd,
      string tag);
    exp_t e;
    logic [7:0] brkm, clr;
    e.ev = model_hits(iv, ia, dv, da, dd);
    brkm = '0;
    for (int k = 0; k < N; k++) brkm[k] = ctrl_m[k][3];
    e.brk = |(e.ev & brkm);
    clr = (we && a == 5'd16) ? wd[7:0] : 8'h00;
    st_m = (st_m & ~clr) | e.ev;
    e.st = st_m;
    e.due = cyc + 1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (we && a < 5'd8) ref_m[a[2:0]] = wd;
    else if (we && a < 5'd16) ctrl_m[a[2:0]] = wd[3:0];
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    fetch_vld = iv; fetch_addr = ia;
    dacc_vld = dv; dacc_addr = da; dacc_data = dd;
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] wd, string tag);
    drive(1'b1, a, wd, 1'b0, '0, 1'b0, '0, '0, tag);
  endtask

  task automatic fetch(logic [31:0] ia, string tag);
    drive(1'b0, '0, '0, 1'b1, ia, 1'b0, '0, '0, tag);
  endtask

  task automatic dacc(logic [31:0] da, logic [31:0] dd, string tag);
    drive(1'b0, '0, '0, 1'b0, '0, 1'b1, da, dd, tag);
  endtask

  task automatic idle(string tag);
    drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, '0, tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (wp_event !== e.ev || brk_req !== e.brk || wp_sticky !== e.st) begin
        errors++;
        $display("FAIL %s: event=%h brk=%b sticky=%h, expected event=%h brk=%b sticky=%h",
                 t, wp_event, brk_req, wp_sticky, e.ev, e.brk, e.st);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin ref_m[k] = '0; ctrl_m[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (wp_event !== 8'h00 || brk_req !== 1'b0 || wp_sticky !== 8'h00) begin
      errors++;
      $display("FAIL R1: event=%h brk=%b sticky=%h, expected 00 0 00",
               wp_event, brk_req, wp_sticky);
    end
    // R1 / R5: references reset to 0 but comparators disabled
    fetch(32'h0, "R1 disabled after reset");
    dacc(32'h0, 32'h0, "R1 data disabled after reset");

    // R10: program instruction comparators
    wr(5'd0, 32'h0000_1000, "R10 ref0 write");
    wr(5'd1, 32'h0000_2000, "R10 ref1 write");
    wr(5'd2, 32'h0000_3000, "R10 ref2 write");
    wr(5'd3, 32'h0000_1000, "R10 ref3 write");
    wr(5'd8,  32'hC, "R10 ctrl0 eq en brk");
    wr(5'd9,  32'h5, "R10 ctrl1 lt en");
    wr(5'd10, 32'h6, "R10 ctrl2 gt en");
    wr(5'd11, 32'h7, "R10 ctrl3 off en");

    // R2/R3/R7: equal, less-than, off; break request from comparator 0
    fetch(32'h0000_1000, "R3 eq and lt hit, off silent, R7 brk");
    idle("R6 single-cycle event pulse");
    fetch(32'h0000_3001, "R3 gt hit without brk");
    fetch(32'h0000_3000, "R3 gt boundary equal no hit");
    // R4: data access only, instruction comparators idle
    dacc(32'h0000_1000, 32'h0000_1000, "R4 data strobe leaves fetch comparators");

    // data comparators
    wr(5'd4, 32'h8000_0000, "R10 ref4 write");
    wr(5'd5, 32'hFFFF_FFFF, "R10 ref5 write");
    wr(5'd6, 32'h0000_0055, "R10 ref6 write");
    wr(5'd7, 32'h0000_0010, "R10 ref7 write");
    wr(5'd12, 32'h5, "R10 ctrl4 lt en");
    wr(5'd13, 32'hC, "R10 ctrl5 eq en brk");
    wr(5'd14, 32'h4, "R10 ctrl6 eq en");
    wr(5'd15, 32'hE, "R10 ctrl7 gt en brk");
    dacc(32'h7FFF_FFFF, 32'h0000_0055, "R3 unsigned lt and R2 data value eq");
    dacc(32'hFFFF_FFFF, 32'h0000_0011, "R2 data addr eq, data gt, R7 brk");
    fetch(32'h7FFF_FFFF, "R4 fetch strobe leaves data comparators");
    drive(1'b0, '0, '0, 1'b1, 32'h0000_1000, 1'b1, 32'h0, 32'h55,
          "R2 fetch and data in one cycle");

    // R5: disabling comparator 2
    wr(5'd10, 32'h2, "R5 ctrl2 disable");
    fetch(32'h0000_4000, "R5 disabled comparator silent");

    // R8: clear by writing ones, zeros no effect
    wr(5'd16, 32'h0000_0000, "R8 zero clear has no effect");
    wr(5'd16, 32'h0000_000F, "R8 clear low nibble");
    idle("R8 sticky state after clear");
    // R9: clear and hit in the same cycle
    drive(1'b1, 5'd16, 32'h0000_0001, 1'b1, 32'h0000_1000, 1'b0, '0, '0,
          "R9 set wins over clear");
    idle("R9 sticky stays set");

    // R10: unmapped writes ignored (24 aliases 8 and 17 aliases 1 if decode is short)
    wr(5'd24, 32'h0000_0000, "R10 unmapped write 24");
    wr(5'd17, 32'h0000_0000, "R10 unmapped write 17");
    wr(5'd31, 32'hFFFF_FFFF, "R10 unmapped write 31");
    fetch(32'h0000_1000, "R10 config unchanged by unmapped writes");

    // R10: write applies from the next cycle only
    drive(1'b1, 5'd0, 32'h0000_5000, 1'b1, 32'h0000_1000, 1'b0, '0, '0,
          "R10 same-cycle access uses old ref");
    fetch(32'h0000_1000, "R10 old ref no longer matches");
    fetch(32'h0000_5000, "R10 new ref matches");
    wr(5'd16, 32'h0000_00FF, "R8 clear all");
    idle("R8 all sticky cleared");
    idle("R6 idle tail");
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule